// File: doc/BRIEF.md
# Programmable Digital Threshold Comparator

This block watches a stream of digital sample codes on one channel and reduces them to a single status bit. Software programs two threshold registers and a control word through a small write port. Each valid sample is compared against the thresholds in one of three modes. Plain mode reports "above the high threshold". Hysteresis mode trips above the high threshold and releases only below the low threshold. Window mode reports "outside the band between the two thresholds".

Optionally the status latches once tripped, until software issues a one-shot clear command. The output pin can be inverted for active-low signalling. It can also be gated to its inactive level while the internal status keeps tracking the samples.

Thresholds are held MSB-aligned in a 16-bit register. Only the top CODE_W bits take part in the comparison.

Top module: `thresh_cmp`

## Requirements
- R1: After reset the two thresholds, the control word and the internal status are all zero, so cmp_out is 0.
- R2: Mode 00 (control bits 1:0): on each valid sample the status becomes 1 if the code is strictly greater than the high threshold, else 0.
- R3: Mode 01: a valid sample above the high threshold sets the status, a valid sample strictly below the low threshold clears it, and any other valid sample leaves it unchanged.
- R4: Mode 10: on each valid sample the status becomes 1 if the code is strictly above the high threshold or strictly below the low threshold, else 0.
- R5: Mode 11 is invalid: samples taken in it leave the status and cmp_out unchanged.
- R6: When samp_valid is low, samp_code has no effect on the status or cmp_out.
- R7: With the latch bit (control bit 2) set, a status of 1 stays 1 whatever samples arrive.
- R8: Writing a word with bit 0 set to address 3 clears the status on the clock edge after the write. The command clears itself, so later samples update the status normally. The clear applies even when latched.
- R9: With the invert bit (control bit 3) set and the output enabled, cmp_out is the complement of the status.
- R10: With the enable bit (control bit 4) clear, cmp_out sits at its inactive level, which equals the invert bit. The status keeps updating and becomes visible once the output is enabled again.
- R11: Address 0 holds the high threshold and address 1 the low threshold. The compared code is register bits 15:6, and bits 5:0 are ignored.
- R12: Every register write and sample takes effect on the rising clock edge where it is presented. cmp_out reflects the new state after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register address: 0 high, 1 low, 2 control, 3 command |
| cfg_wdata | input | 16 | Register write data |
| samp_valid | input | 1 | Qualifies samp_code for one cycle |
| samp_code | input | CODE_W | Input sample code |
| cmp_out | output | 1 | Comparator output pin level |

## Verification
Each valid mode gets a full upward and downward sweep of every input code against fixed thresholds. This catches an off-by-one in the strict comparisons at the threshold codes. A hysteresis that forgets its state would make the rising and falling sweeps match, and a window that fails to see below the low threshold would show up in the same sweep. The threshold registers are written with ones in their ignored low bits, so a misaligned field shifts every trip point. The latch test checks that a tripped output survives low samples, clears on the command, and then resumes tracking. A command that failed to self-clear would pin the output low. Gating and inversion are checked by tripping the status while the output is disabled and then re-enabling it.

// File: rtl/thresh_cmp.sv
module thresh_cmp #(
  parameter int CODE_W = 10,
  parameter int REG_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_addr,
  input  logic [REG_W-1:0]  cfg_wdata,
  input  logic              samp_valid,
  input  logic [CODE_W-1:0] samp_code,
  output logic              cmp_out
);
  localparam int LSB = REG_W - CODE_W;

  logic [CODE_W-1:0] hi_code, lo_code;
  logic [1:0]        mode;
  logic              latch_en, inv_en, out_en;
  logic              clr_pend;
  logic              st, st_nx;
  logic              above, below;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_code  <= '0;
      lo_code  <= '0;
      mode     <= 2'b00;
      latch_en <= 1'b0;
      inv_en   <= 1'b0;
      out_en   <= 1'b0;
      clr_pend <= 1'b0;
    end else begin
      clr_pend <= cfg_we && (cfg_addr == 2'd3) && cfg_wdata[0];
      if (cfg_we) begin
        case (cfg_addr)
          2'd0: hi_code <= cfg_wdata[REG_W-1:LSB];
          2'd1: lo_code <= cfg_wdata[REG_W-1:LSB];
          2'd2: begin
            mode     <= cfg_wdata[1:0];
            latch_en <= cfg_wdata[2];
            inv_en   <= cfg_wdata[3];
            out_en   <= cfg_wdata[4];
          end
          default: ;
        endcase
      end
    end
  end

  assign above = samp_code > hi_code;
  assign below = samp_code < lo_code;

  always_comb begin
    st_nx = st;
    if (samp_valid && !(latch_en && st)) begin
      case (mode)
        2'b00: st_nx = above;
        2'b01: begin
          if (above)      st_nx = 1'b1;
          else if (below) st_nx = 1'b0;
        end
        2'b10: st_nx = above | below;
        default: st_nx = st;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= 1'b0;
    else        st <= clr_pend ? 1'b0 : st_nx;
  end

  assign cmp_out = out_en ? (st ^ inv_en) : inv_en;

  a_r2_plain: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && mode == 2'b00 && !clr_pend && !(latch_en && st))
    |=> (st == ($past(samp_code) > $past(hi_code))));

  a_r3_hyst_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && mode == 2'b01 && !clr_pend &&
     samp_code <= hi_code && samp_code >= lo_code) |=> $stable(st));

  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    (samp_valid && mode == 2'b10 && !clr_pend && !(latch_en && st))
    |=> (st == (($past(samp_code) > $past(hi_code)) ||
                ($past(samp_code) < $past(lo_code)))));

  a_r5_invalid_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11 && !clr_pend) |=> $stable(st));

  a_r6_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!samp_valid && !clr_pend) |=> $stable(st));

  a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && st && !clr_pend) |=> st);

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_pend |=> !st);

  a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend && !(cfg_we && cfg_addr == 2'd3)) |=> !clr_pend);
endmodule

// File: tb/test_thresh_cmp.sv
module test_thresh_cmp;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        samp_valid = 1'b0;
  logic [9:0]  samp_code = '0;
  logic        cmp_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  int  e_hi = 0, e_lo = 0;
  int  e_mode = 0;
  bit  e_latch = 0, e_inv = 0, e_oe = 0;
  bit  e_st = 0;

  thresh_cmp #(.CODE_W(10), .REG_W(16)) i_thresh_cmp (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .samp_valid(samp_valid), .samp_code(samp_code),
    .cmp_out(cmp_out));

  always #10 clk = ~clk;

  function automatic bit exp_out();
    return e_oe ? (e_st ^ e_inv) : e_inv;
  endfunction

  task automatic chk(input string tag, input bit got, input bit exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: cmp_out=%0b expected=%0b (mode=%0d)", tag, got, exp, e_mode);
    end
  endtask

  task automatic wr(input int addr, input logic [15:0] data);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = addr[1:0]; cfg_wdata = data;
    @(posedge clk);
    case (addr)
      0: e_hi = int'(data[15:6]);
      1: e_lo = int'(data[15:6]);
      2: begin
        e_mode = int'(data[1:0]); e_latch = data[2];
        e_inv = data[3]; e_oe = data[4];
      end
      default: ;
    endcase
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic ctrl(input int mode, input bit latch, input bit inv, input bit oe);
    wr(2, {11'b0, oe, inv, latch, mode[1:0]});
  endtask

  task automatic smp(input string tag, input int c, input bit v);
    @(negedge clk);
    samp_valid = v; samp_code = c[9:0];
    @(posedge clk);
    if (v && !(e_latch && e_st)) begin
      case (e_mode)
        0: e_st = (c > e_hi);
        1: if (c > e_hi) e_st = 1; else if (c < e_lo) e_st = 0;
        2: e_st = (c > e_hi) || (c < e_lo);
        default: ;
      endcase
    end
    #5 chk(tag, cmp_out, exp_out());
    @(negedge clk);
    samp_valid = 1'b0;
  endtask

  task automatic clear_cmd(input string tag);
    wr(3, 16'h0001);
    @(posedge clk);
    e_st = 0;
    #5 chk(tag, cmp_out, exp_out());
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #35;
    chk("R1 reset output", cmp_out, 1'b0);
    rst_n = 1'b1;
    #10;
    chk("R1 after release", cmp_out, 1'b0);

    // R11: low bits filled with ones must be ignored
    wr(0, {10'd600, 6'h3F});
    wr(1, {10'd300, 6'h2A});

    // R2 plain sweep
    ctrl(0, 0, 0, 1);
    for (int c = 0; c < 1024; c++) smp("R2 plain up", c, 1);
    for (int c = 1023; c >= 0; c--) smp("R2 plain down", c, 1);
    smp("R11 at high code", 600, 1);
    smp("R11 above high code", 601, 1);

    // R3 hysteresis sweep
    ctrl(1, 0, 0, 1);
    smp("R3 init low", 0, 1);
    for (int c = 0; c < 1024; c++) smp("R3 hyst up", c, 1);
    for (int c = 1023; c >= 0; c--) smp("R3 hyst down", c, 1);
    smp("R3 set", 700, 1);
    smp("R3 hold at low code", 300, 1);
    smp("R3 release", 299, 1);

    // R4 window sweep
    ctrl(2, 0, 0, 1);
    for (int c = 0; c < 1024; c++) smp("R4 window up", c, 1);
    for (int c = 1023; c >= 0; c--) smp("R4 window down", c, 1);
    smp("R11 low boundary", 300, 1);
    smp("R11 below low", 299, 1);

    // R5 invalid mode holds
    ctrl(2, 0, 0, 1);
    smp("R4 trip", 900, 1);
    ctrl(3, 0, 0, 1);
    for (int c = 0; c < 1024; c += 37) smp("R5 invalid mode", c, 1);
    ctrl(0, 0, 0, 1);
    smp("R2 low", 10, 1);
    ctrl(3, 0, 0, 1);
    smp("R5 invalid mode high", 1000, 1);

    // R6 samples without valid
    ctrl(0, 0, 0, 1);
    smp("R2 clear", 0, 1);
    smp("R6 no valid high", 1023, 0);
    smp("R2 trip", 1023, 1);
    smp("R6 no valid low", 0, 0);

    // R7 / R8 latching and clear
    ctrl(0, 1, 0, 1);
    smp("R7 trip", 700, 1);
    smp("R7 hold on low", 100, 1);
    smp("R7 hold on zero", 0, 1);
    clear_cmd("R8 clear latched");
    smp("R8 stays clear", 100, 1);
    smp("R8 retrips", 800, 1);
    clear_cmd("R8 clear again");
    wr(3, 16'h0000);
    smp("R8 no-op command", 0, 1);
    smp("R8 trip", 650, 1);
    wr(3, 16'h0000);
    #1 chk("R8 bit0 zero no clear", cmp_out, exp_out());

    // R8 clear in window mode
    ctrl(2, 0, 0, 1);
    smp("R4 outside", 50, 1);
    clear_cmd("R8 clear window");

    // R9 inversion
    ctrl(0, 0, 1, 1);
    smp("R9 inverted low", 100, 1);
    smp("R9 inverted high", 900, 1);

    // R10 output gating
    ctrl(0, 0, 1, 0);
    smp("R10 gated inverted", 100, 1);
    ctrl(0, 0, 0, 0);
    smp("R10 gated trip", 900, 1);
    ctrl(0, 0, 0, 1);
    #1 chk("R10 status tracked while gated", cmp_out, 1'b1);
    ctrl(0, 0, 1, 0);
    #1 chk("R12 control write applies", cmp_out, 1'b1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule